// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches up to eight analog quantities by sampling a shared stream of ADC results. Each monitor channel names one ADC input (an 8-bit tag) and keeps a 16-bit lower and a 16-bit upper limit. Three shared interval timers run while monitoring is started. A channel that uses one of them is armed on each tick, and the block pulses a conversion request. The next result on the stream whose tag matches the channel's input is compared against both limits. A crossing sets a sticky status bit. An interrupt line reports every status bit whose enable is set.

Software configures the block through a byte-wide register port. Each channel has an eight-byte bank. Monitoring starts only after a global enable has been set and a start request has been written. The ADC conversion itself, calibration, averaging and decimation are done elsewhere. The decimation and averaging settings are only held here for the converter to use.

Top module: `adc_thresh_mon`

## Requirements
- R1: After reset the status registers at 0x0A and 0x0B read 0x00, `irq` and `conv_req` are low, 0x46 reads 0x00, every channel's interval-select byte reads 0x03, and 0x0F reads the number of channels (8 by default).
- R2: The global bytes 0x42, 0x43, 0x44 and 0x45 store and return all eight bits. A channel's control byte keeps only bits 5:0 (3:0 settle code, 5:4 calibration select). Its enable byte keeps only bits 7, 1 and 0. Its interval-select byte keeps only bits 1:0. All other bits of these bytes read zero.
- R3: Channel n's bank occupies 0x60+8n to 0x67+8n. The byte order in a bank is: input select, lower limit low byte, lower limit high byte, upper limit low byte, upper limit high byte, interval select, control, enable. Bit n of each status register belongs to channel n.
- R4: Interval select 0, 1 and 2 pick timer 1, timer 2 and timer 3. Timer 1's code is register 0x44. Timer 2's code is 0x45 bits 7:4, and timer 3's code is 0x45 bits 3:0. Timer k ticks every UNIT_k*(code+1) clock cycles. A tick that arms at least one channel raises `conv_req` for one cycle, one cycle after the tick.
- R5: A channel whose interval select is 3 is never armed, so no result ever sets its status.
- R6: Timers run and channels are armed only while the global enable (0x46 bit 7) is set and a start has been requested by writing bit 7 of 0x47. 0x47 bit 7 reads back as the started state. Clearing the global enable also clears the started state and stops all requests.
- R7: An armed channel consumes the first result whose tag equals its input select, then stays disarmed until its next tick. Results with another tag, and results that arrive while the channel is not armed, are ignored.
- R8: A consumed result at or below the lower limit sets the channel's bit in 0x0A. A consumed result at or above the upper limit sets its bit in 0x0B. The status bit is set at the clock edge that samples the result.
- R9: A channel whose measurement enable (enable byte bit 7) is clear is never armed and never sets status.
- R10: Status bits stay set until software writes 1 to that bit of its status register. Writing 0 has no effect.
- R11: `irq` is registered. It is high one cycle after any 0x0A bit is set with enable bit 0 of its channel set, or any 0x0B bit is set with enable bit 1 of its channel set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| res_valid | input | 1 | ADC result present this cycle |
| res_tag | input | 8 | ADC input the result belongs to |
| res_data | input | 16 | ADC result code |
| conv_req | output | 1 | One-cycle conversion request pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a result that arrives while its channel is armed. Arming comes from free-running interval timers whose phase cannot be seen at the ports. The stimulus therefore waits for a `conv_req` pulse, which marks the cycle in which a channel became armed, and only then sends the matching or non-matching result. Periods are measured between consecutive pulses with only one channel active. The channels that are disabled or set to "no interval" are configured with limits that any sample would trip, so that status on them could only come from a wrongly armed channel.

// File: rtl/thm_pkg.sv
package thm_pkg;
   localparam int MAX_CH    = 8;
   localparam int SEL_W     = 8;
   localparam int THR_W     = 16;
   localparam int NUM_TMR   = 3;
   localparam int BANK_SZ   = 8;

   localparam logic [7:0] A_STAT_LO = 8'h0A;
   localparam logic [7:0] A_STAT_HI = 8'h0B;
   localparam logic [7:0] A_NCH     = 8'h0F;
   localparam logic [7:0] A_DECIM   = 8'h42;
   localparam logic [7:0] A_AVG     = 8'h43;
   localparam logic [7:0] A_IVL1    = 8'h44;
   localparam logic [7:0] A_IVL23   = 8'h45;
   localparam logic [7:0] A_GEN     = 8'h46;
   localparam logic [7:0] A_START   = 8'h47;
   localparam logic [7:0] A_BANK0   = 8'h60;

   localparam int EN_MEAS_BIT = 7;
   localparam int EN_HIE_BIT  = 1;
   localparam int EN_LIE_BIT  = 0;

   typedef enum logic [2:0] {
      OFF_SEL  = 3'd0,
      OFF_LOTL = 3'd1,
      OFF_LOTH = 3'd2,
      OFF_HITL = 3'd3,
      OFF_HITH = 3'd4,
      OFF_TSEL = 3'd5,
      OFF_CTL  = 3'd6,
      OFF_EN   = 3'd7
   } bank_off_e;

   typedef enum logic [1:0] {
      TSEL_T1  = 2'd0,
      TSEL_T2  = 2'd1,
      TSEL_T3  = 2'd2,
      TSEL_OFF = 2'd3
   } tsel_e;
endpackage

// File: rtl/thm_interval.sv
module thm_interval #(
   parameter int UNIT   = 1000,
   parameter int CODE_W = 8,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // period = UNIT * (code + 1) cycles, counter wraps at period - 1
   assign limit = CNT_W'(UNIT) * (CNT_W'(code) + CNT_W'(1)) - CNT_W'(1);
   assign tick  = run && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (cnt_q >= limit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/thm_channel.sv
module thm_channel
   import thm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bank_we,
   input  logic [2:0]         bank_off,
   input  logic [7:0]         wdata,
   input  logic [NUM_TMR-1:0] tick,
   input  logic               run,
   input  logic               res_valid,
   input  logic [SEL_W-1:0]   res_tag,
   input  logic [THR_W-1:0]   res_data,
   input  logic               clr_lo,
   input  logic               clr_hi,
   output logic [7:0]         rd_byte,
   output logic               st_lo,
   output logic               st_hi,
   output logic               meas,
   output logic               hie,
   output logic               lie,
   output logic               arm_evt
);
   logic [SEL_W-1:0] sel_q;
   logic [THR_W-1:0] lo_thr_q;
   logic [THR_W-1:0] hi_thr_q;
   tsel_e            tsel_q;
   logic [3:0]       settle_q;
   logic [1:0]       cal_q;
   logic             meas_q, hie_q, lie_q;
   logic             armed_q;
   logic             st_lo_q, st_hi_q;
   logic             sel_tick, take, hit_lo, hit_hi;

   // configuration bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= '0;
         lo_thr_q <= '0;
         hi_thr_q <= '0;
         tsel_q   <= TSEL_OFF;
         settle_q <= '0;
         cal_q    <= '0;
         meas_q   <= 1'b0;
         hie_q    <= 1'b0;
         lie_q    <= 1'b0;
      end else if (bank_we) begin
         unique case (bank_off_e'(bank_off))
            OFF_SEL:  sel_q          <= wdata;
            OFF_LOTL: lo_thr_q[7:0]  <= wdata;
            OFF_LOTH: lo_thr_q[15:8] <= wdata;
            OFF_HITL: hi_thr_q[7:0]  <= wdata;
            OFF_HITH: hi_thr_q[15:8] <= wdata;
            OFF_TSEL: tsel_q         <= tsel_e'(wdata[1:0]);
            OFF_CTL: begin
               settle_q <= wdata[3:0];
               cal_q    <= wdata[5:4];
            end
            OFF_EN: begin
               meas_q <= wdata[EN_MEAS_BIT];
               hie_q  <= wdata[EN_HIE_BIT];
               lie_q  <= wdata[EN_LIE_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (tsel_q)
         TSEL_T1: sel_tick = tick[0];
         TSEL_T2: sel_tick = tick[1];
         TSEL_T3: sel_tick = tick[2];
         default: sel_tick = 1'b0;
      endcase
   end

   assign arm_evt = run && meas_q && sel_tick;
   assign take    = armed_q && res_valid && (res_tag == sel_q);
   assign hit_lo  = take && (res_data <= lo_thr_q);
   assign hit_hi  = take && (res_data >= hi_thr_q);

   // arming: a new tick wins over consumption in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n || !run || !meas_q) begin
         armed_q <= 1'b0;
      end else if (arm_evt) begin
         armed_q <= 1'b1;
      end else if (take) begin
         armed_q <= 1'b0;
      end
   end

   // sticky status, a new crossing wins over a clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_lo_q <= 1'b0;
         st_hi_q <= 1'b0;
      end else begin
         st_lo_q <= hit_lo || (st_lo_q && !clr_lo);
         st_hi_q <= hit_hi || (st_hi_q && !clr_hi);
      end
   end

   always_comb begin
      unique case (bank_off_e'(bank_off))
         OFF_SEL:  rd_byte = sel_q;
         OFF_LOTL: rd_byte = lo_thr_q[7:0];
         OFF_LOTH: rd_byte = lo_thr_q[15:8];
         OFF_HITL: rd_byte = hi_thr_q[7:0];
         OFF_HITH: rd_byte = hi_thr_q[15:8];
         OFF_TSEL: rd_byte = {6'b0, tsel_q};
         OFF_CTL:  rd_byte = {2'b0, cal_q, settle_q};
         OFF_EN:   rd_byte = {meas_q, 5'b0, hie_q, lie_q};
         default:  rd_byte = 8'h00;
      endcase
   end

   assign st_lo = st_lo_q;
   assign st_hi = st_hi_q;
   assign meas  = meas_q;
   assign hie   = hie_q;
   assign lie   = lie_q;
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
   import thm_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int T1_UNIT = 1000,
   parameter int T2_UNIT = 100000,
   parameter int T3_UNIT = 400000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              res_valid,
   input  logic [SEL_W-1:0]  res_tag,
   input  logic [THR_W-1:0]  res_data,
   output logic              conv_req,
   output logic              irq
);
   localparam int MAX_UNIT = (T1_UNIT > T2_UNIT) ?
                             ((T1_UNIT > T3_UNIT) ? T1_UNIT : T3_UNIT) :
                             ((T2_UNIT > T3_UNIT) ? T2_UNIT : T3_UNIT);
   localparam int CNT_W    = $clog2(MAX_UNIT * 256 + 1);
   localparam int BANK_END = 'h60 + BANK_SZ * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
         $error("NUM_CH must lie in 1..8");
      end
      if (T1_UNIT < 2 || T2_UNIT < 2 || T3_UNIT < 2) begin : g_bad_unit
         $error("timer units must be at least 2 cycles");
      end
   endgenerate

   // global registers
   logic [7:0] decim_q, avg_q, ivl1_q, ivl23_q;
   logic       gen_en_q, start_q, run;
   logic       conv_q, irq_q;

   // decode
   logic [8:0] addr_x;
   logic [7:0] rel;
   logic       in_bank;
   logic [2:0] bank_idx;
   logic [7:0] clr_lo_v, clr_hi_v;

   assign addr_x   = {1'b0, reg_addr};
   assign in_bank  = (addr_x >= 9'h060) && (addr_x < 9'(BANK_END));
   assign rel      = reg_addr - A_BANK0;
   assign bank_idx = rel[5:3];
   assign clr_lo_v = (reg_we && reg_addr == A_STAT_LO) ? reg_wdata : 8'h00;
   assign clr_hi_v = (reg_we && reg_addr == A_STAT_HI) ? reg_wdata : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         decim_q  <= '0;
         avg_q    <= '0;
         ivl1_q   <= '0;
         ivl23_q  <= '0;
         gen_en_q <= 1'b0;
      end else if (reg_we) begin
         unique case (reg_addr)
            A_DECIM: decim_q  <= reg_wdata;
            A_AVG:   avg_q    <= reg_wdata;
            A_IVL1:  ivl1_q   <= reg_wdata;
            A_IVL23: ivl23_q  <= reg_wdata;
            A_GEN:   gen_en_q <= reg_wdata[7];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !gen_en_q) begin
         start_q <= 1'b0;
      end else if (reg_we && reg_addr == A_START && reg_wdata[7]) begin
         start_q <= 1'b1;
      end
   end

   assign run = gen_en_q && start_q;

   // interval timers
   logic [7:0]         tcode [NUM_TMR];
   logic [NUM_TMR-1:0] tick;

   assign tcode[0] = ivl1_q;
   assign tcode[1] = {4'h0, ivl23_q[7:4]};
   assign tcode[2] = {4'h0, ivl23_q[3:0]};

   generate
      for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
         localparam int UNIT_K = (k == 0) ? T1_UNIT : (k == 1) ? T2_UNIT : T3_UNIT;
         thm_interval #(
            .UNIT   (UNIT_K),
            .CODE_W (8),
            .CNT_W  (CNT_W)
         ) u_ivl (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .code  (tcode[k]),
            .tick  (tick[k])
         );
      end
   endgenerate

   // channels (unused slots tie off)
   logic [7:0]        ch_rd [MAX_CH];
   logic [MAX_CH-1:0] st_lo, st_hi, meas_en, hi_ie, lo_ie, arm_v;

   generate
      for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
         if (i < NUM_CH) begin : g_live
            thm_channel u_ch (
               .clk       (clk),
               .rst_n     (rst_n),
               .bank_we   (reg_we && in_bank && bank_idx == 3'(i)),
               .bank_off  (reg_addr[2:0]),
               .wdata     (reg_wdata),
               .tick      (tick),
               .run       (run),
               .res_valid (res_valid),
               .res_tag   (res_tag),
               .res_data  (res_data),
               .clr_lo    (clr_lo_v[i]),
               .clr_hi    (clr_hi_v[i]),
               .rd_byte   (ch_rd[i]),
               .st_lo     (st_lo[i]),
               .st_hi     (st_hi[i]),
               .meas      (meas_en[i]),
               .hie       (hi_ie[i]),
               .lie       (lo_ie[i]),
               .arm_evt   (arm_v[i])
            );
         end else begin : g_tie
            assign ch_rd[i]   = 8'h00;
            assign st_lo[i]   = 1'b0;
            assign st_hi[i]   = 1'b0;
            assign meas_en[i] = 1'b0;
            assign hi_ie[i]   = 1'b0;
            assign lo_ie[i]   = 1'b0;
            assign arm_v[i]   = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conv_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         conv_q <= |arm_v;
         irq_q  <= |((st_lo & lo_ie) | (st_hi & hi_ie));
      end
   end

   assign conv_req = conv_q;
   assign irq      = irq_q;

   // read mux
   always_comb begin
      if (in_bank) begin
         reg_rdata = ch_rd[bank_idx];
      end else begin
         unique case (reg_addr)
            A_STAT_LO: reg_rdata = st_lo;
            A_STAT_HI: reg_rdata = st_hi;
            A_NCH:     reg_rdata = 8'(NUM_CH);
            A_DECIM:   reg_rdata = decim_q;
            A_AVG:     reg_rdata = avg_q;
            A_IVL1:    reg_rdata = ivl1_q;
            A_IVL23:   reg_rdata = ivl23_q;
            A_GEN:     reg_rdata = {gen_en_q, 7'b0};
            A_START:   reg_rdata = {start_q, 7'b0};
            default:   reg_rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/thm_checker.sv
module thm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [7:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       res_valid,
   input logic       conv_req,
   input logic       irq,
   input logic       run,
   input logic [7:0] st_lo,
   input logic [7:0] st_hi,
   input logic [7:0] meas_en,
   input logic [7:0] lo_ie,
   input logic [7:0] hi_ie
);
   // R9
   disabled_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((st_lo | st_hi) & ~$past(st_lo | st_hi) & ~$past(meas_en)) == 8'h00));

   // R7
   status_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((st_lo | st_hi) & ~$past(st_lo | st_hi)) != 8'h00) |-> $past(res_valid));

   // R6
   conv_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> $past(run));

   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lo_ie | hi_ie) == 8'h00) |-> !irq);

   // R10
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_we) && $past(reg_addr) == 8'h0A && $past(reg_wdata) == 8'hFF
       && !$past(res_valid)) |-> (st_lo == 8'h00));
endmodule

bind adc_thresh_mon thm_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .res_valid (res_valid),
   .conv_req  (conv_req),
   .irq       (irq),
   .run       (run),
   .st_lo     (st_lo),
   .st_hi     (st_hi),
   .meas_en   (meas_en),
   .lo_ie     (lo_ie),
   .hi_ie     (hi_ie)
);

// File: tb/adc_thresh_mon_test.sv
module adc_thresh_mon_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        res_valid = 1'b0;
   logic [7:0]  res_tag = 8'h00;
   logic [15:0] res_data = 16'h0000;
   logic        conv_req;
   logic        irq;

   int nvec = 0;
   int nfail = 0;

   typedef struct {
      logic [7:0] addr;
      logic [7:0] exp;
      string      tag;
   } rd_item_t;

   rd_item_t sbq[$];
   event     rd_ev;

   always #2 clk = ~clk;

   adc_thresh_mon #(
      .NUM_CH  (8),
      .T1_UNIT (4),
      .T2_UNIT (8),
      .T3_UNIT (16)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .res_data  (res_data),
      .conv_req  (conv_req),
      .irq       (irq)
   );

   // scoreboard monitor: pops expected register reads and compares
   initial begin
      rd_item_t it;
      forever begin
         @(rd_ev);
         it = sbq.pop_front();
         nvec++;
         if (reg_rdata !== it.exp) begin
            nfail++;
            $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h",
                     it.tag, it.addr, reg_rdata, it.exp);
         end
      end
   end

   task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      rd_item_t it;
      @(negedge clk);
      reg_addr = a;
      it.addr = a;
      it.exp  = e;
      it.tag  = tag;
      sbq.push_back(it);
      #1;
      ->rd_ev;
      wait (sbq.size() == 0);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic send(input logic [7:0] t, input logic [15:0] d);
      @(negedge clk);
      res_valid = 1'b1;
      res_tag   = t;
      res_data  = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // returns cycles until the next conv_req pulse, or -1 if none within limit
   task automatic wait_conv(input int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!conv_req && n < limit);
      if (!conv_req) n = -1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      expect_rd(8'h0A, 8'h00, "R1 low status");
      expect_rd(8'h0B, 8'h00, "R1 high status");
      expect_rd(8'h0F, 8'h08, "R1 channel count");
      expect_rd(8'h65, 8'h03, "R1 ch0 interval select");
      expect_rd(8'h46, 8'h00, "R1 global enable");
      chk("R1 irq", int'(irq), 0);
      chk("R1 conv_req", int'(conv_req), 0);

      // R2 and R3: storage and masking
      wr(8'h42, 8'h5C);
      expect_rd(8'h42, 8'h5C, "R2 decimation");
      wr(8'h45, 8'hA4);
      expect_rd(8'h45, 8'hA4, "R2 interval codes");
      wr(8'h78, 8'h5A);
      expect_rd(8'h78, 8'h5A, "R3 ch3 input select");
      wr(8'h7A, 8'h12);
      expect_rd(8'h7A, 8'h12, "R3 ch3 lower limit high byte");
      wr(8'h7D, 8'hFE);
      expect_rd(8'h7D, 8'h02, "R2 interval select mask");
      wr(8'h7E, 8'hFF);
      expect_rd(8'h7E, 8'h3F, "R2 control mask");
      wr(8'h7F, 8'hFF);
      expect_rd(8'h7F, 8'h83, "R2 enable mask");
      wr(8'h7F, 8'h00);
      wr(8'h7D, 8'h03);

      // channel 0: input 0x11, lower 0x0100, upper 0x0F00, timer 1
      wr(8'h60, 8'h11);
      wr(8'h61, 8'h00); wr(8'h62, 8'h01);
      wr(8'h63, 8'h00); wr(8'h64, 8'h0F);
      wr(8'h65, 8'h00);
      wr(8'h67, 8'h83);
      wr(8'h44, 8'h01);

      // R6 no activity before enable and start
      wait_conv(40, n);
      chk("R6 no request while disabled", n, -1);
      wr(8'h46, 8'h80);
      wait_conv(40, n);
      chk("R6 no request before start", n, -1);
      wr(8'h47, 8'h80);
      expect_rd(8'h47, 8'h80, "R6 started state");
      wait_conv(100, n);
      chk("R6 request after start", int'(n > 0), 1);
      // R4 timer 1 period = 4 * (1 + 1)
      wait_conv(100, n);
      chk("R4 timer1 period", n, 8);

      // R7 wrong tag ignored, R8 low crossing
      send(8'h22, 16'h0050);
      idle(2);
      expect_rd(8'h0A, 8'h00, "R7 other tag ignored");
      send(8'h11, 16'h0080);
      idle(2);
      expect_rd(8'h0A, 8'h01, "R8 low crossing");
      expect_rd(8'h0B, 8'h00, "R8 no high crossing");
      chk("R11 irq on low status", int'(irq), 1);

      // R10 clear behaviour
      wr(8'h0A, 8'h00);
      expect_rd(8'h0A, 8'h01, "R10 zero write keeps status");
      wr(8'h0A, 8'h01);
      expect_rd(8'h0A, 8'h00, "R10 one write clears");
      idle(2);
      chk("R11 irq drops", int'(irq), 0);

      // R8 upper boundary equal
      wait_conv(100, n);
      send(8'h11, 16'h0F00);
      idle(2);
      expect_rd(8'h0B, 8'h01, "R8 high at equal limit");
      expect_rd(8'h0A, 8'h00, "R8 high value not low");
      chk("R11 irq on high status", int'(irq), 1);

      // R11 masking by enables
      wr(8'h67, 8'h81);
      idle(2);
      chk("R11 masked high", int'(irq), 0);
      expect_rd(8'h0B, 8'h01, "R10 status kept while masked");
      wr(8'h67, 8'h83);
      idle(2);
      chk("R11 unmasked high", int'(irq), 1);

      // R8 lower boundary equal, then a value between limits
      wr(8'h0B, 8'h01);
      wait_conv(100, n);
      send(8'h11, 16'h0100);
      idle(2);
      expect_rd(8'h0A, 8'h01, "R8 low at equal limit");
      expect_rd(8'h0B, 8'h00, "R8 low value not high");
      wr(8'h0A, 8'h01);
      wait_conv(100, n);
      send(8'h11, 16'h0500);
      idle(2);
      expect_rd(8'h0A, 8'h00, "R8 mid value low clear");
      expect_rd(8'h0B, 8'h00, "R8 mid value high clear");

      // R9 ch1 measurement off, R5 ch2 no interval; both would trip
      wr(8'h68, 8'h11); wr(8'h69, 8'hFF); wr(8'h6A, 8'hFF);
      wr(8'h6D, 8'h00); wr(8'h6F, 8'h03);
      wr(8'h70, 8'h11); wr(8'h71, 8'hFF); wr(8'h72, 8'hFF);
      wr(8'h75, 8'h03); wr(8'h77, 8'h81);
      wait_conv(100, n);
      send(8'h11, 16'h0080);
      idle(2);
      expect_rd(8'h0A, 8'h01, "R9 disabled channel bit clear");
      expect_rd(8'h0A, 8'h01, "R5 no-interval channel bit clear");
      wr(8'h0A, 8'hFF);

      // R4 timer 3 on channel 7, R3 bit position
      wr(8'h67, 8'h00);
      wr(8'h98, 8'h33);
      wr(8'h99, 8'h00); wr(8'h9A, 8'h00);
      wr(8'h9B, 8'h00); wr(8'h9C, 8'h80);
      wr(8'h9D, 8'h02);
      wr(8'h45, 8'h21);
      wr(8'h9F, 8'h82);
      wait_conv(200, n);
      wait_conv(200, n);
      chk("R4 timer3 period", n, 32);
      send(8'h33, 16'h9000);
      idle(2);
      expect_rd(8'h0B, 8'h80, "R3 channel 7 status bit");
      chk("R11 irq from channel 7", int'(irq), 1);

      // R6 stop by clearing global enable, R7 result without arming ignored
      wr(8'h0B, 8'hFF);
      wr(8'h46, 8'h00);
      expect_rd(8'h47, 8'h00, "R6 started state cleared");
      wait_conv(100, n);
      chk("R6 no request after stop", n, -1);
      send(8'h33, 16'h9000);
      idle(2);
      expect_rd(8'h0B, 8'h00, "R7 unarmed result ignored");

      finish_run();
   end
endmodule